// File: doc/BRIEF.md
# Charger Register Access Slave (two-wire serial)

This block is a two-wire serial bus slave that answers at the 7-bit address 0x48. It gives a charger controller's system host access to a small register set: a status register and two configuration registers, plus an unlock register and a memory-program control bit. The status register records over-voltage, thermal and input under-voltage events arriving as single-cycle pulses. Reading it clears it. An open-drain fault output is pulled low while the over-voltage bit is set. The configuration fields leave the block as plain level outputs for the charger's regulation logic.

The bus lines are oversampled on the system clock. Each line passes through a two-stage synchronizer and a stability filter, and only then are START, STOP and clock edges detected. A write transaction first loads the register pointer from its first data byte. Every later byte is written to the pointed register, and the pointer then advances. A read starts at the current pointer and advances after every byte fetched, so a write of the pointer followed by a repeated START gives a random read. The slave never stretches the clock. The bus has no valid/ready handshake: the master owns the timing, the slave acknowledges every data byte it receives, and a master NACK ends a read.

Top module: `chg_i2c_regs`

## Requirements
- R1: The slave pulls SDA low in the acknowledge slot only for an address byte whose upper seven bits equal 0x48. For any other address it leaves SDA released for the whole transaction.
- R2: In a write transaction the first data byte loads the register pointer, and each following byte is written to the pointer and then increments it. Every byte read increments the pointer. The pointer survives a repeated START and a STOP, so a later read with no pointer byte continues from it.
- R3: Status register 0x00 holds over-voltage in bit 7, thermal shutdown in bit 3 and input under-voltage in bit 1. Its other bits always read 0. Writes to 0x00 have no effect.
- R4: An over-voltage event pulse drives `flt_oe` high (pin pulled low) from the next clock. Thermal and under-voltage pulses set only their status bits and leave `flt_oe` low.
- R5: Fetching register 0x00 for a read clears every status bit, and `flt_oe` falls once bit 7 is clear. An event present in the clearing cycle leaves its bit set.
- R6: Register 0x11 resets to 0x00, and only its bit 0 (unlock) is writable. While bit 0 is 0, writes to 0x02, 0x04 and 0x12 are ignored and reads of them return 0x00.
- R7: Register 0x02 holds the 3-bit termination voltage field in bits 3:1, register 0x04 holds the 4-bit charge current limit in bits 7:4, and register 0x12 holds the program-control bit in bit 0. Unused bits read 0, and the fields drive `cfg_vterm`, `cfg_imax` and `ee_prog`.
- R8: Reads of any address outside 0x00, 0x02, 0x04, 0x11 and 0x12 return 0x00, and writes to them change nothing.
- R9: After a master NACK on a read byte the slave releases SDA and does not drive it again before the next START.
- R10: A pulse on SCL or SDA shorter than `FILT_CYC` clock cycles is ignored, so it neither adds a bit nor forms a START or STOP.
- R11: After reset SDA and the fault output are released, and all registers and configuration outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| evt_ov | input | 1 | Over-voltage event pulse (fault) |
| evt_tsd | input | 1 | Thermal shutdown event pulse (warning) |
| evt_uv | input | 1 | Input under-voltage event pulse (warning) |
| flt_oe | output | 1 | 1 pulls the open-drain fault pin low |
| cfg_vterm | output | 3 | Termination voltage setting |
| cfg_imax | output | 4 | Maximum charge current setting |
| ee_prog | output | 1 | Memory program control bit |

## Verification
A corrupted pointer shows up in the very next byte the master reads. A corrupted status register shows up either on `flt_oe` one clock after the bad update or in the next status read. A broken unlock gate shows on the configuration outputs within a clock of the eighth SCL rise of the offending data byte, so a model compared on every idle clock catches it before the transaction ends. Errors in the bit engine surface as a wrong level on SDA at the master's sampling point of that same bit.

// File: rtl/chg_i2c_pkg.sv
package chg_i2c_pkg;
  localparam logic [7:0] REG_STS  = 8'h00;
  localparam logic [7:0] REG_CFG1 = 8'h02;
  localparam logic [7:0] REG_CFG3 = 8'h04;
  localparam logic [7:0] REG_UNLK = 8'h11;
  localparam logic [7:0] REG_EEC  = 8'h12;

  localparam int STS_OV  = 7;
  localparam int STS_TSD = 3;
  localparam int STS_UV  = 1;
  localparam logic [7:0] STS_MASK = (8'h1 << STS_OV) | (8'h1 << STS_TSD) | (8'h1 << STS_UV);

  localparam int VTERM_W   = 3;
  localparam int VTERM_LSB = 1;
  localparam int IMAX_W    = 4;
  localparam int IMAX_LSB  = 4;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_ADDR,
    BUS_WR,
    BUS_RD,
    BUS_WAIT
  } bus_st_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_CYC    = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync;
  logic [CW-1:0]          cnt;
  logic                   s_last;

  assign s_last = sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= '1;
      cnt  <= '0;
      q_o  <= 1'b1;
    end else begin
      sync <= {sync[SYNC_STAGES-2:0], d_i};
      if (s_last != q_o) begin
        if (cnt == CW'(FILT_CYC - 1)) begin
          q_o <= s_last;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o != $past(q_o)) |-> ($past(s_last) == q_o)); // R10
endmodule

// File: rtl/i2c_slave_core.sv
module i2c_slave_core
  import chg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_f,
  input  logic       sda_f,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       rd_en,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data
);
  bus_st_t    st;
  logic       scl_q, sda_q;
  logic [3:0] bitcnt;
  logic [7:0] rxsh, txsh, ptr;
  logic       ack_ok, is_read, ptr_loaded, nack;
  logic       scl_rise, scl_fall, bus_start, bus_stop;
  logic [7:0] rx_byte;

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign bus_start = scl_f & scl_q & sda_q & ~sda_f;
  assign bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
  assign rx_byte   = {rxsh[6:0], sda_f};
  assign rd_addr   = ptr;

  always_comb begin
    rd_en = 1'b0;
    if (scl_fall && bitcnt == 4'd9) begin
      if (st == BUS_ADDR && ack_ok && is_read) rd_en = 1'b1;
      if (st == BUS_RD && !nack)               rd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= BUS_IDLE;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      bitcnt <= '0;
      rxsh <= '0;
      txsh <= '0;
      ptr <= '0;
      ack_ok <= 1'b0;
      is_read <= 1'b0;
      ptr_loaded <= 1'b0;
      nack <= 1'b0;
      sda_oe <= 1'b0;
      wr_en <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      wr_en <= 1'b0;
      if (bus_start) begin
        st <= BUS_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        ptr_loaded <= 1'b0;
      end else if (bus_stop) begin
        st <= BUS_IDLE;
        sda_oe <= 1'b0;
      end else if (rd_en) begin
        st <= BUS_RD;
        txsh <= rd_data;
        sda_oe <= ~rd_data[7];
        ptr <= ptr + 8'd1;
        bitcnt <= '0;
      end else begin
        case (st)
          BUS_ADDR, BUS_WR: begin
            if (scl_rise) begin
              if (bitcnt < 4'd8) rxsh <= rx_byte;
              bitcnt <= bitcnt + 4'd1;
              if (bitcnt == 4'd7) begin
                if (st == BUS_ADDR) begin
                  ack_ok  <= (rx_byte[7:1] == DEV_ADDR);
                  is_read <= rx_byte[0];
                end else begin
                  ack_ok <= 1'b1;
                  if (!ptr_loaded) begin
                    ptr <= rx_byte;
                    ptr_loaded <= 1'b1;
                  end else begin
                    wr_en <= 1'b1;
                    wr_addr <= ptr;
                    wr_data <= rx_byte;
                    ptr <= ptr + 8'd1;
                  end
                end
              end
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= ack_ok;
              end else if (bitcnt == 4'd9) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                if (!ack_ok) st <= BUS_WAIT;
                else         st <= BUS_WR;
              end
            end
          end
          BUS_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
              if (bitcnt == 4'd8) nack <= sda_f;
            end else if (scl_fall) begin
              if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                sda_oe <= ~txsh[6];
                txsh <= {txsh[6:0], 1'b0};
              end else if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
              end else if (bitcnt == 4'd9) begin
                sda_oe <= 1'b0;
                st <= BUS_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BUS_IDLE || st == BUS_WAIT) |-> !sda_oe); // R9
  AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BUS_ADDR && sda_oe) |-> (rxsh[7:1] == DEV_ADDR)); // R1
  AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr == wr_addr + 8'd1)); // R2
  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (ptr == $past(ptr) + 8'd1)); // R2
endmodule

// File: rtl/chg_reg_bank.sv
module chg_reg_bank
  import chg_i2c_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               rd_en,
  input  logic [7:0]         rd_addr,
  output logic [7:0]         rd_data,
  input  logic               evt_ov,
  input  logic               evt_tsd,
  input  logic               evt_uv,
  output logic               flt_oe,
  output logic [VTERM_W-1:0] cfg_vterm,
  output logic [IMAX_W-1:0]  cfg_imax,
  output logic               ee_prog
);
  logic [7:0] sts, ev_set;
  logic       unlk;
  logic       sts_clr;

  always_comb begin
    ev_set = '0;
    ev_set[STS_OV]  = evt_ov;
    ev_set[STS_TSD] = evt_tsd;
    ev_set[STS_UV]  = evt_uv;
  end

  assign sts_clr = rd_en && (rd_addr == REG_STS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
      unlk <= 1'b0;
      cfg_vterm <= '0;
      cfg_imax <= '0;
      ee_prog <= 1'b0;
    end else begin
      sts <= (sts_clr ? 8'h00 : sts) | ev_set;
      if (wr_en) begin
        case (wr_addr)
          REG_UNLK: unlk <= wr_data[0];
          REG_CFG1: if (unlk) cfg_vterm <= wr_data[VTERM_LSB +: VTERM_W];
          REG_CFG3: if (unlk) cfg_imax <= wr_data[IMAX_LSB +: IMAX_W];
          REG_EEC:  if (unlk) ee_prog <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_STS:  rd_data = sts;
      REG_UNLK: rd_data[0] = unlk;
      REG_CFG1: if (unlk) rd_data[VTERM_LSB +: VTERM_W] = cfg_vterm;
      REG_CFG3: if (unlk) rd_data[IMAX_LSB +: IMAX_W] = cfg_imax;
      REG_EEC:  if (unlk) rd_data[0] = ee_prog;
      default: ;
    endcase
  end

  assign flt_oe = sts[STS_OV];

  AST_STS_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (sts & ~STS_MASK) == 8'h00); // R3
  AST_FAULT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ov |=> flt_oe); // R4
  AST_CLR_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !evt_ov && !evt_tsd && !evt_uv) |=> (sts == 8'h00)); // R5
  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tsd |=> sts[STS_TSD]); // R5
  AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !unlk |=> ($stable(cfg_vterm) && $stable(cfg_imax) && $stable(ee_prog))); // R6
endmodule

// File: rtl/chg_i2c_regs.sv
module chg_i2c_regs
  import chg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h48,
  parameter int         FILT_CYC    = 13,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe,
  input  logic                evt_ov,
  input  logic                evt_tsd,
  input  logic                evt_uv,
  output logic                flt_oe,
  output logic [VTERM_W-1:0]  cfg_vterm,
  output logic [IMAX_W-1:0]   cfg_imax,
  output logic                ee_prog
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_l, filt_l;
  logic       wr_en, rd_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

  assign raw_l = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_line_filter #(
      .FILT_CYC(FILT_CYC),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_filt (
      .clk(clk),
      .rst_n(rst_n),
      .d_i(raw_l[g]),
      .q_o(filt_l[g])
    );
  end

  i2c_slave_core #(.DEV_ADDR(DEV_ADDR)) u_core (
    .clk(clk),
    .rst_n(rst_n),
    .scl_f(filt_l[1]),
    .sda_f(filt_l[0]),
    .sda_oe(sda_oe),
    .wr_en(wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_en(rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  chg_reg_bank u_bank (
    .clk(clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_en(rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .evt_ov(evt_ov),
    .evt_tsd(evt_tsd),
    .evt_uv(evt_uv),
    .flt_oe(flt_oe),
    .cfg_vterm(cfg_vterm),
    .cfg_imax(cfg_imax),
    .ee_prog(ee_prog)
  );
endmodule

// File: tb/chg_i2c_regs_test.sv
`timescale 1ns/1ps
module chg_i2c_regs_test;
  localparam int QP = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic evt_ov = 1'b0, evt_tsd = 1'b0, evt_uv = 1'b0;
  logic sda_oe, flt_oe, ee_prog;
  logic [2:0] cfg_vterm;
  logic [3:0] cfg_imax;
  wire  sda_ln = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  chg_i2c_regs uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_ln), .sda_oe(sda_oe),
    .evt_ov(evt_ov), .evt_tsd(evt_tsd), .evt_uv(evt_uv), .flt_oe(flt_oe),
    .cfg_vterm(cfg_vterm), .cfg_imax(cfg_imax), .ee_prog(ee_prog)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit cmp_en = 0;

  // behavioural reference state
  logic [7:0] m_sts = 0;
  logic       m_unlk = 0, m_ee = 0;
  logic [2:0] m_vt = 0;
  logic [3:0] m_im = 0;
  logic [7:0] m_ptr = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // idle-time comparison against the model on every clock
  always @(posedge clk) begin
    #1;
    if (cmp_en && !done) begin
      n_chk++;
      if (flt_oe !== m_sts[7] || cfg_vterm !== m_vt || cfg_imax !== m_im || ee_prog !== m_ee) begin
        n_fail++;
        if (n_fail < 20)
          $display("FAIL R4/R6/R7 per-clock: actual flt=%0b vt=%0h im=%0h ee=%0b expected flt=%0b vt=%0h im=%0h ee=%0b",
                   flt_oe, cfg_vterm, cfg_imax, ee_prog, m_sts[7], m_vt, m_im, m_ee);
      end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return m_sts;
      8'h11: return {7'b0, m_unlk};
      8'h02: return m_unlk ? {4'b0, m_vt, 1'b0} : 8'h00;
      8'h04: return m_unlk ? {m_im, 4'b0} : 8'h00;
      8'h12: return m_unlk ? {7'b0, m_ee} : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic mdl_write(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h11: m_unlk = d[0];
      8'h02: if (m_unlk) m_vt = d[3:1];
      8'h04: if (m_unlk) m_im = d[7:4];
      8'h12: if (m_unlk) m_ee = d[0];
      default: ;
    endcase
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b, input bit glitch);
    wt(QP);
    m_sda = b;
    if (glitch) begin
      wt(5); m_scl = 1'b1; wt(5); m_scl = 1'b0; wt(QP - 10);
    end else wt(QP);
    m_scl = 1'b1;
    wt(2 * QP);
    m_scl = 1'b0;
  endtask

  task automatic get_bit(output logic v);
    wt(QP);
    m_sda = 1'b1;
    wt(QP);
    m_scl = 1'b1;
    wt(QP);
    v = sda_ln;
    wt(QP);
    m_scl = 1'b0;
  endtask

  task automatic bus_start();
    cmp_en = 0;
    m_sda = 1'b0; wt(2 * QP); m_scl = 1'b0;
  endtask

  task automatic bus_rstart();
    wt(QP); m_sda = 1'b1; wt(QP); m_scl = 1'b1; wt(2 * QP); m_sda = 1'b0; wt(2 * QP); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wt(QP); m_sda = 1'b0; wt(QP); m_scl = 1'b1; wt(2 * QP); m_sda = 1'b1; wt(2 * QP);
    wt(40);
    cmp_en = 1;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack_n);
    for (int i = 7; i >= 0; i--) put_bit(b[i], glitch && i == 4);
    get_bit(ack_n);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      get_bit(v);
      d[i] = v;
    end
    put_bit(nack, 1'b0);
  endtask

  task automatic write_regs(input logic [7:0] p, input int n, input logic [7:0] d0,
                            input logic [7:0] d1, input logic [7:0] d2, input bit glitch);
    logic a;
    logic [7:0] dv [3];
    dv[0] = d0; dv[1] = d1; dv[2] = d2;
    bus_start();
    send_byte(8'h90, glitch, a);
    chk(glitch ? "R10 address ack through glitch" : "R1 write address ack", a, 0);
    send_byte(p, 1'b0, a);
    m_ptr = p;
    for (int i = 0; i < n; i++) begin
      send_byte(dv[i], 1'b0, a);
      chk("R2 data byte ack", a, 0);
      mdl_write(m_ptr, dv[i]);
      m_ptr = m_ptr + 1;
    end
    bus_stop();
  endtask

  // read n bytes; when use_ptr, load pointer then repeated START
  task automatic read_regs(input bit use_ptr, input logic [7:0] p, input int n, input string req);
    logic a;
    logic [7:0] d, e;
    bus_start();
    if (use_ptr) begin
      send_byte(8'h90, 1'b0, a);
      send_byte(p, 1'b0, a);
      m_ptr = p;
      bus_rstart();
    end
    send_byte(8'h91, 1'b0, a);
    chk("R1 read address ack", a, 0);
    for (int i = 0; i < n; i++) begin
      e = exp_rd(m_ptr);
      if (m_ptr == 8'h00) m_sts = {evt_ov, 3'b0, evt_tsd, 1'b0, evt_uv, 1'b0};
      m_ptr = m_ptr + 1;
      recv_byte(i == n - 1, d);
      chk(req, d, e);
    end
    wt(30);
    chk("R9 SDA released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic pulse(input logic ov, input logic tsd, input logic uv);
    @(negedge clk);
    evt_ov = ov; evt_tsd = tsd; evt_uv = uv;
    m_sts = m_sts | {ov, 3'b0, tsd, 1'b0, uv, 1'b0};
    @(negedge clk);
    evt_ov = 0; evt_tsd = 0; evt_uv = 0;
    wt(3);
  endtask

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic a;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    // R11 reset state
    chk("R11 sda_oe", sda_oe, 0);
    chk("R11 flt_oe", flt_oe, 0);
    chk("R11 cfg outputs", {cfg_vterm, cfg_imax, ee_prog}, 0);
    cmp_en = 1;
    read_regs(1, 8'h11, 1, "R11 unlock reg reset 0x00");

    // R1 foreign address left unacknowledged
    bus_start();
    send_byte(8'h92, 1'b0, a);
    chk("R1 foreign address NACK", a, 1);
    bus_stop();

    // R4 warnings do not drive fault; R3 layout
    pulse(0, 1, 0);
    pulse(0, 0, 1);
    chk("R4 warnings leave fault released", flt_oe, 0);
    read_regs(1, 8'h00, 1, "R3 status layout 0x0A");
    read_regs(1, 8'h00, 1, "R5 status cleared after read");

    // R4 fault raised, R5 released after read
    pulse(1, 0, 0);
    chk("R4 over-voltage pulls fault", flt_oe, 1);
    read_regs(1, 8'h00, 1, "R3 status over-voltage bit 7");
    chk("R5 fault released after read", flt_oe, 0);

    // R3 writes to status ignored
    write_regs(8'h00, 1, 8'hFF, 8'h00, 8'h00, 0);
    read_regs(1, 8'h00, 1, "R3 status write ignored");

    // R6 locked config
    write_regs(8'h02, 1, 8'hFF, 8'h00, 8'h00, 0);
    read_regs(1, 8'h02, 1, "R6 locked read 0x00");
    chk("R6 locked vterm unchanged", cfg_vterm, 0);

    // R6 unlock, only bit 0
    write_regs(8'h11, 1, 8'hFF, 8'h00, 8'h00, 0);
    read_regs(1, 8'h11, 1, "R6 unlock reads 0x01");

    // R2/R7/R8 burst write and read with auto-increment
    write_regs(8'h02, 3, 8'hFF, 8'h5A, 8'hFF, 0);
    chk("R7 vterm field", cfg_vterm, 7);
    chk("R7 imax field", cfg_imax, 15);
    read_regs(1, 8'h02, 3, "R2/R7/R8 burst read");
    write_regs(8'h12, 1, 8'h01, 8'h00, 8'h00, 0);
    chk("R7 program bit", ee_prog, 1);

    // R2/R9 NACK ends read, then current-address read continues
    read_regs(1, 8'h10, 2, "R9 two-byte read");
    read_regs(0, 8'h00, 1, "R2 current-address read 0x12");

    // R8 unimplemented write ignored
    write_regs(8'h05, 1, 8'hFF, 8'h00, 8'h00, 0);
    read_regs(1, 8'h05, 1, "R8 unimplemented reads 0x00");

    // R6 relock blocks writes
    write_regs(8'h11, 2, 8'h00, 8'h00, 8'h00, 0);
    write_regs(8'h04, 1, 8'h30, 8'h00, 8'h00, 0);
    chk("R6 relocked imax unchanged", cfg_imax, 15);
    read_regs(1, 8'h12, 1, "R6 relocked read 0x00");

    // R5 event held across the clearing fetch survives
    @(negedge clk);
    evt_tsd = 1;
    m_sts = m_sts | 8'h08;
    read_regs(1, 8'h00, 1, "R5 held event read");
    @(negedge clk);
    evt_tsd = 0;
    read_regs(1, 8'h00, 1, "R5 event kept through clear");
    read_regs(1, 8'h00, 1, "R5 cleared afterwards");

    // R10 short SCL glitch inside address byte
    write_regs(8'h11, 1, 8'h01, 8'h00, 8'h00, 1);
    read_regs(1, 8'h11, 1, "R10 transfer intact after glitch");

    wt(20);
    finish_up();
  end
endmodule